// File: doc/BRIEF.md
# Virtual machine instruction slot decoder

This block takes 64-bit instruction slots of a small register-based virtual machine and turns each one into a registered bundle of decoded fields. A slot holds, in memory order, an opcode byte, a register byte, a 16-bit offset and a 32-bit immediate. A static endianness input picks how the register nibbles and the offset and immediate bytes are read. The decoder splits the opcode into its arithmetic/jump view (operation, operand source, class) and its load/store view (mode, size). It sign-extends the offset and the immediate to 64 bits and reports the class as a one-hot vector.

One form, the wide immediate load, takes two consecutive slots. The decoder raises a wait flag after the first slot. It reports the instruction only after the second slot arrives, and then builds a 64-bit immediate from the two immediate fields. Three extended encodings are legal only while an enable input is high: signed divide, signed modulo and call through a register. Reserved load/store modes and any operation that a class does not define are reported on an illegal output, and such a result never carries the valid flag.

Top module: `slot_decoder`

## Requirements
- R1: While rst_n is low at a clock edge, dec_valid_o, illegal_o and need_second_o go low and every field output goes to zero.
- R2: A slot is taken at a rising edge where slot_valid_i is high, and its results appear after that edge. Byte k of the slot sits in slot_i[8k+7:8k], and byte 0 is the opcode. opcode_o carries it, with op_o = bits 7:4, src_is_reg_o = bit 3 (1 = register operand), mode_o = bits 7:5 and size_o = bits 4:3.
- R3: With big_endian_i low, dst_o is bits 3:0 of byte 1 and src_o is bits 7:4 of byte 1. The offset is {byte3, byte2} and the immediate is {byte7, byte6, byte5, byte4}.
- R4: With big_endian_i high, dst_o is bits 7:4 of byte 1 and src_o is bits 3:0 of byte 1. The offset is {byte2, byte3} and the immediate is {byte4, byte5, byte6, byte7}.
- R5: off_o and imm_o hold the offset and the immediate sign-extended to 64 bits. For any instruction other than the wide load, wide_imm_o equals imm_o.
- R6: Opcode 0x18 (class 000, size 11, mode 000) is the wide load. After its first slot, need_second_o is high and dec_valid_o is low. The next accepted slot ends the wait: dec_valid_o and wide_o go high, and wide_imm_o = {second immediate, first immediate}, each read in the selected byte order. The second slot's other 32 bits have no effect, and the other fields keep the first slot's values.
- R7: For the load/store classes (000 to 011), the mode codes 100, 101 and 111 set illegal_o and never dec_valid_o.
- R8: Three encodings set ext_only_o: op 0xE or 0xF in class 100 or 111, and class 101 with bit 3 set and op 0x8. Each is valid when ext_en_i is high at acceptance and illegal when it is low.
- R9: Each class accepts only certain encodings; anything else sets illegal_o without dec_valid_o. Class 100 takes ops 0x0 to 0xD, and class 111 takes ops 0x0 to 0xC (0xD is rejected). Class 101 takes ops 0x0 to 0xD. Class 110 takes ops 0x1 to 0x7 and 0xA to 0xD. Class 000 takes modes 001 and 010 at any size, and mode 000 only at size 11. Classes 001 and 010 take mode 011. Class 011 takes mode 011, and mode 110 at sizes 00 or 11.
- R10: With every result, class_hot_o has exactly bit n set, where n is the opcode's class field.
- R11: dec_valid_o and illegal_o each pulse for one cycle per finished instruction and are never high together. They stay low in any cycle after an edge without an accepted slot, and the field outputs then hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| big_endian_i | input | 1 | Static byte/nibble order select (1 = big-endian) |
| ext_en_i | input | 1 | Enables the extended-only encodings |
| slot_valid_i | input | 1 | slot_i holds a slot to take this cycle |
| slot_i | input | 64 | Instruction slot, byte k at bits 8k+7:8k |
| dec_valid_o | output | 1 | One-cycle pulse: legal instruction fully decoded |
| illegal_o | output | 1 | One-cycle pulse: slot rejected |
| need_second_o | output | 1 | Waiting for the second slot of a wide load |
| opcode_o | output | 8 | Raw opcode byte |
| op_o | output | 4 | Operation code (opcode bits 7:4) |
| src_is_reg_o | output | 1 | Operand source, 1 = register |
| mode_o | output | 3 | Load/store mode (opcode bits 7:5) |
| size_o | output | 2 | Load/store size (opcode bits 4:3) |
| class_hot_o | output | 8 | One-hot class |
| dst_o | output | 4 | Destination register index |
| src_o | output | 4 | Source register index |
| off_o | output | 64 | Sign-extended offset |
| imm_o | output | 64 | Sign-extended immediate |
| wide_imm_o | output | 64 | Assembled 64-bit immediate |
| wide_o | output | 1 | Result is a wide load |
| ext_only_o | output | 1 | Encoding belongs to the extended set |

## Verification
The properties assume that big_endian_i is fixed for the whole of an instruction and that ext_en_i is meaningful only on the cycle a slot is taken. The ext-gate property reads ext_en_i one cycle back for that reason. The bench sets both inputs together with each slot on the falling edge and does not change the endianness between the two slots of a wide load. Every slot is presented for exactly one cycle and is followed by an idle cycle. This keeps the quiet-cycle property meaningful, and each check sees a single result.

// File: rtl/slot_dec_pkg.sv
// Shared encodings for the instruction slot decoder.
// Assumes the 8-bit opcode layout: class in bits 2:0, size in 4:3, mode in 7:5.
package slot_dec_pkg;

    typedef enum logic [2:0] {
        CLS_LD    = 3'b000,
        CLS_LDX   = 3'b001,
        CLS_ST    = 3'b010,
        CLS_STX   = 3'b011,
        CLS_ALU   = 3'b100,
        CLS_JMP   = 3'b101,
        CLS_JMP32 = 3'b110,
        CLS_ALU64 = 3'b111
    } insn_class_e;

    typedef enum logic [2:0] {
        MD_IMM  = 3'b000,
        MD_ABS  = 3'b001,
        MD_IND  = 3'b010,
        MD_MEM  = 3'b011,
        MD_RSV4 = 3'b100,
        MD_RSV5 = 3'b101,
        MD_XADD = 3'b110,
        MD_RSV7 = 3'b111
    } ls_mode_e;

    typedef enum logic [1:0] {
        SZ_WORD = 2'b00,
        SZ_HALF = 2'b01,
        SZ_BYTE = 2'b10,
        SZ_DBL  = 2'b11
    } ls_size_e;

    localparam logic [3:0] OPC_CALL = 4'h8;
    localparam logic [3:0] OPC_SWAP = 4'hD;
    localparam logic [3:0] OPC_SDIV = 4'hE;
    localparam logic [3:0] OPC_SMOD = 4'hF;

    localparam int OPCODE_W = 8;
    localparam int CLASS_N  = 8;

endpackage

// File: rtl/sd_field_extract.sv
// Field extractor: splits one slot into opcode, register indices, offset and
// immediate, honouring the selected byte/nibble order. Purely combinational.
// Assumes byte k of the slot is at bits 8k+7:8k and fields are byte aligned.
module sd_field_extract #(
    parameter int REG_W = 4,
    parameter int OFF_W = 16,
    parameter int IMM_W = 32
) (
    input  logic [slot_dec_pkg::OPCODE_W+2*REG_W+OFF_W+IMM_W-1:0] slot,
    input  logic                big_endian,
    output logic [slot_dec_pkg::OPCODE_W-1:0] opcode,
    output logic [REG_W-1:0]    dst_idx,
    output logic [REG_W-1:0]    src_idx,
    output logic [OFF_W-1:0]    off_raw,
    output logic [IMM_W-1:0]    imm_raw
);
    localparam int OPW       = slot_dec_pkg::OPCODE_W;
    localparam int RB_LO     = OPW;
    localparam int OFF_BYTES = OFF_W / 8;
    localparam int IMM_BYTES = IMM_W / 8;
    localparam int OFF_BASE  = (OPW + 2 * REG_W) / 8;
    localparam int IMM_BASE  = OFF_BASE + OFF_BYTES;

    logic [2*REG_W-1:0] reg_byte;

    // Opcode and register byte are at fixed positions.
    assign opcode   = slot[OPW-1:0];
    assign reg_byte = slot[RB_LO +: 2*REG_W];

    // Nibble order of the register byte follows the endianness mode.
    always_comb begin
        if (big_endian) begin
            dst_idx = reg_byte[2*REG_W-1:REG_W];
            src_idx = reg_byte[REG_W-1:0];
        end else begin
            dst_idx = reg_byte[REG_W-1:0];
            src_idx = reg_byte[2*REG_W-1:REG_W];
        end
    end

    // Offset bytes: lowest memory byte is least significant in little-endian.
    for (genvar i = 0; i < OFF_BYTES; i++) begin : g_off
        assign off_raw[i*8 +: 8] = big_endian ? slot[(OFF_BASE+OFF_BYTES-1-i)*8 +: 8]
                                              : slot[(OFF_BASE+i)*8 +: 8];
    end

    // Immediate bytes, same rule.
    for (genvar i = 0; i < IMM_BYTES; i++) begin : g_imm
        assign imm_raw[i*8 +: 8] = big_endian ? slot[(IMM_BASE+IMM_BYTES-1-i)*8 +: 8]
                                              : slot[(IMM_BASE+i)*8 +: 8];
    end

endmodule

// File: rtl/sd_legality.sv
// Legality classifier: decides from the opcode whether an encoding is
// defined, whether it belongs to the extended set, and whether it is the
// two-slot wide load. Purely combinational; ext_en gates extended encodings.
module sd_legality (
    input  logic [slot_dec_pkg::OPCODE_W-1:0] opcode,
    input  logic ext_en,
    output logic legal,
    output logic ext_only,
    output logic wide
);
    import slot_dec_pkg::*;

    insn_class_e cls;
    ls_mode_e    mode;
    ls_size_e    size;
    logic [3:0]  op;
    logic        src_reg;

    // Opcode sub-fields in both views.
    always_comb begin
        cls     = insn_class_e'(opcode[2:0]);
        mode    = ls_mode_e'(opcode[7:5]);
        size    = ls_size_e'(opcode[4:3]);
        op      = opcode[7:4];
        src_reg = opcode[3];
    end

    // Per-class acceptance rules.
    always_comb begin
        legal    = 1'b0;
        ext_only = 1'b0;
        wide     = 1'b0;
        case (cls)
            CLS_ALU, CLS_ALU64: begin
                if (op == OPC_SDIV || op == OPC_SMOD) begin
                    ext_only = 1'b1;
                    legal    = ext_en;
                end else if (op == OPC_SWAP) begin
                    legal = (cls == CLS_ALU);
                end else begin
                    legal = 1'b1;
                end
            end
            CLS_JMP: begin
                if (op == OPC_CALL && src_reg) begin
                    ext_only = 1'b1;
                    legal    = ext_en;
                end else begin
                    legal = (op <= 4'hD);
                end
            end
            CLS_JMP32: legal = (op inside {[4'h1:4'h7], [4'hA:4'hD]});
            CLS_LD: begin
                case (mode)
                    MD_IMM: begin
                        legal = (size == SZ_DBL);
                        wide  = (size == SZ_DBL);
                    end
                    MD_ABS, MD_IND: legal = 1'b1;
                    default:        legal = 1'b0;
                endcase
            end
            CLS_LDX, CLS_ST: legal = (mode == MD_MEM);
            CLS_STX: legal = (mode == MD_MEM) ||
                             (mode == MD_XADD && (size == SZ_WORD || size == SZ_DBL));
            default: legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/slot_decoder.sv
// Instruction slot decoder top: registers the decoded bundle of each slot,
// waits for a second slot on the wide load and splices its immediate on top.
// Assumes big_endian_i is static across both slots of a wide load.
// Synchronous active-low reset.
module slot_decoder #(
    parameter int REG_W = 4,
    parameter int OFF_W = 16,
    parameter int IMM_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                big_endian_i,
    input  logic                ext_en_i,
    input  logic                slot_valid_i,
    input  logic [slot_dec_pkg::OPCODE_W+2*REG_W+OFF_W+IMM_W-1:0] slot_i,
    output logic                dec_valid_o,
    output logic                illegal_o,
    output logic                need_second_o,
    output logic [slot_dec_pkg::OPCODE_W-1:0] opcode_o,
    output logic [3:0]          op_o,
    output logic                src_is_reg_o,
    output logic [2:0]          mode_o,
    output logic [1:0]          size_o,
    output logic [slot_dec_pkg::CLASS_N-1:0] class_hot_o,
    output logic [REG_W-1:0]    dst_o,
    output logic [REG_W-1:0]    src_o,
    output logic [2*IMM_W-1:0]  off_o,
    output logic [2*IMM_W-1:0]  imm_o,
    output logic [2*IMM_W-1:0]  wide_imm_o,
    output logic                wide_o,
    output logic                ext_only_o
);
    import slot_dec_pkg::*;

    localparam int XLEN = 2 * IMM_W;

    logic [OPCODE_W-1:0] f_opcode;
    logic [REG_W-1:0]    f_dst, f_src;
    logic [OFF_W-1:0]    f_off;
    logic [IMM_W-1:0]    f_imm;
    logic                l_legal, l_ext, l_wide;
    logic [CLASS_N-1:0]  hot_d;
    logic [OPCODE_W-1:0] opcode_q;

    sd_field_extract #(.REG_W(REG_W), .OFF_W(OFF_W), .IMM_W(IMM_W)) u_fields (
        .slot       (slot_i),
        .big_endian (big_endian_i),
        .opcode     (f_opcode),
        .dst_idx    (f_dst),
        .src_idx    (f_src),
        .off_raw    (f_off),
        .imm_raw    (f_imm)
    );

    sd_legality u_legal (
        .opcode   (f_opcode),
        .ext_en   (ext_en_i),
        .legal    (l_legal),
        .ext_only (l_ext),
        .wide     (l_wide)
    );

    // One-hot class of the incoming opcode.
    always_comb begin
        hot_d = '0;
        hot_d[f_opcode[2:0]] = 1'b1;
    end

    // Result bundle register and the wide-load wait state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid_o   <= 1'b0;
            illegal_o     <= 1'b0;
            need_second_o <= 1'b0;
            opcode_q      <= '0;
            class_hot_o   <= '0;
            dst_o         <= '0;
            src_o         <= '0;
            off_o         <= '0;
            imm_o         <= '0;
            wide_imm_o    <= '0;
            wide_o        <= 1'b0;
            ext_only_o    <= 1'b0;
        end else begin
            dec_valid_o <= 1'b0;
            illegal_o   <= 1'b0;
            if (slot_valid_i) begin
                if (need_second_o) begin
                    wide_imm_o[XLEN-1:IMM_W] <= f_imm;
                    need_second_o            <= 1'b0;
                    dec_valid_o              <= 1'b1;
                end else begin
                    opcode_q    <= f_opcode;
                    class_hot_o <= hot_d;
                    dst_o       <= f_dst;
                    src_o       <= f_src;
                    off_o       <= {{(XLEN-OFF_W){f_off[OFF_W-1]}}, f_off};
                    imm_o       <= {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};
                    wide_imm_o  <= {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};
                    wide_o      <= l_wide;
                    ext_only_o  <= l_ext;
                    if (!l_legal)     illegal_o     <= 1'b1;
                    else if (l_wide)  need_second_o <= 1'b1;
                    else              dec_valid_o   <= 1'b1;
                end
            end
        end
    end

    // Opcode views are slices of the registered opcode.
    assign opcode_o     = opcode_q;
    assign op_o         = opcode_q[7:4];
    assign src_is_reg_o = opcode_q[3];
    assign mode_o       = opcode_q[7:5];
    assign size_o       = opcode_q[4:3];

    // R11: valid and illegal are exclusive and never coincide with waiting.
    assert_valid_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_o |-> (!illegal_o && !need_second_o));

    // R11: no result pulse after an edge without an accepted slot.
    assert_quiet_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(slot_valid_i) |-> (!dec_valid_o && !illegal_o));

    // R6: a slot taken while waiting finishes the wide load.
    assert_second_slot_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (need_second_o && slot_valid_i) |=> (dec_valid_o && wide_o && !need_second_o));

    // R8: an extended-only result is valid only if the enable was high.
    assert_ext_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && ext_only_o) |-> $past(ext_en_i));

    // R7: a valid load/store never carries a reserved mode.
    assert_no_reserved_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && (|class_hot_o[3:0])) |-> !(mode_o inside {3'b100, 3'b101, 3'b111}));

    // R10: every result carries exactly one class bit.
    assert_class_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o || illegal_o) |-> ($countones(class_hot_o) == 1));

endmodule

// File: tb/sim_slot_decoder.sv
// Directed bench for the instruction slot decoder.
module sim_slot_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        big_endian_i = 1'b0;
    logic        ext_en_i = 1'b0;
    logic        slot_valid_i = 1'b0;
    logic [63:0] slot_i = '0;
    logic        dec_valid_o, illegal_o, need_second_o;
    logic [7:0]  opcode_o;
    logic [3:0]  op_o;
    logic        src_is_reg_o;
    logic [2:0]  mode_o;
    logic [1:0]  size_o;
    logic [7:0]  class_hot_o;
    logic [3:0]  dst_o, src_o;
    logic [63:0] off_o, imm_o, wide_imm_o;
    logic        wide_o, ext_only_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    slot_decoder u0 (
        .clk(clk), .rst_n(rst_n), .big_endian_i(big_endian_i), .ext_en_i(ext_en_i),
        .slot_valid_i(slot_valid_i), .slot_i(slot_i),
        .dec_valid_o(dec_valid_o), .illegal_o(illegal_o), .need_second_o(need_second_o),
        .opcode_o(opcode_o), .op_o(op_o), .src_is_reg_o(src_is_reg_o), .mode_o(mode_o),
        .size_o(size_o), .class_hot_o(class_hot_o), .dst_o(dst_o), .src_o(src_o),
        .off_o(off_o), .imm_o(imm_o), .wide_imm_o(wide_imm_o), .wide_o(wide_o),
        .ext_only_o(ext_only_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Build a slot in memory byte order from its fields.
    function automatic logic [63:0] mk(input logic [7:0] opc, input logic [3:0] dst,
                                       input logic [3:0] src, input logic [15:0] off,
                                       input logic [31:0] imm, input logic be);
        logic [7:0] b [8];
        b[0] = opc;
        b[1] = be ? {dst, src} : {src, dst};
        if (be) begin
            b[2] = off[15:8]; b[3] = off[7:0];
            b[4] = imm[31:24]; b[5] = imm[23:16]; b[6] = imm[15:8]; b[7] = imm[7:0];
        end else begin
            b[2] = off[7:0]; b[3] = off[15:8];
            b[4] = imm[7:0]; b[5] = imm[15:8]; b[6] = imm[23:16]; b[7] = imm[31:24];
        end
        return {b[7], b[6], b[5], b[4], b[3], b[2], b[1], b[0]};
    endfunction

    // Present one slot for a single cycle, then return on the next falling edge.
    task automatic send(input logic [63:0] s, input logic be, input logic ext);
        @(negedge clk);
        slot_i = s; big_endian_i = be; ext_en_i = ext; slot_valid_i = 1'b1;
        @(negedge clk);
        slot_valid_i = 1'b0;
    endtask

    task automatic expect_status(input string req, input logic v, input logic ill,
                                 input logic wait2);
        chk(req, "dec_valid_o", {63'd0, dec_valid_o}, {63'd0, v});
        chk(req, "illegal_o", {63'd0, illegal_o}, {63'd0, ill});
        chk(req, "need_second_o", {63'd0, need_second_o}, {63'd0, wait2});
    endtask

    task automatic t_reset;
        // R1: everything zero after reset
        expect_status("R1", 1'b0, 1'b0, 1'b0);
        chk("R1", "opcode_o", {56'd0, opcode_o}, 64'd0);
        chk("R1", "class_hot_o", {56'd0, class_hot_o}, 64'd0);
        chk("R1", "off_o", off_o, 64'd0);
        chk("R1", "wide_imm_o", wide_imm_o, 64'd0);
    endtask

    task automatic t_little_alu;
        // R2 R3 R5 R10: ALU64 add, register source, little-endian
        send(mk(8'h0F, 4'h3, 4'hA, 16'hFFFE, 32'h8000_0001, 1'b0), 1'b0, 1'b0);
        expect_status("R2", 1'b1, 1'b0, 1'b0);
        chk("R2", "op_o", {60'd0, op_o}, 64'd0);
        chk("R2", "src_is_reg_o", {63'd0, src_is_reg_o}, 64'd1);
        chk("R3", "dst_o", {60'd0, dst_o}, 64'h3);
        chk("R3", "src_o", {60'd0, src_o}, 64'hA);
        chk("R5", "off_o", off_o, 64'hFFFF_FFFF_FFFF_FFFE);
        chk("R5", "imm_o", imm_o, 64'hFFFF_FFFF_8000_0001);
        chk("R5", "wide_imm_o", wide_imm_o, 64'hFFFF_FFFF_8000_0001);
        chk("R10", "class_hot_o", {56'd0, class_hot_o}, 64'h80);
    endtask

    task automatic t_big_jump;
        // R4 R5 R10: conditional jump, immediate source, big-endian
        send(mk(8'h55, 4'h9, 4'h2, 16'h1234, 32'h00C0_FFEE, 1'b1), 1'b1, 1'b0);
        expect_status("R4", 1'b1, 1'b0, 1'b0);
        chk("R4", "dst_o", {60'd0, dst_o}, 64'h9);
        chk("R4", "src_o", {60'd0, src_o}, 64'h2);
        chk("R4", "off_o", off_o, 64'h1234);
        chk("R4", "imm_o", imm_o, 64'h00C0_FFEE);
        chk("R10", "class_hot_o", {56'd0, class_hot_o}, 64'h20);
        // R4: raw slot bytes read as big-endian give a different result than little-endian
        send(mk(8'h0F, 4'h1, 4'h2, 16'h0001, 32'h0000_0001, 1'b0), 1'b1, 1'b0);
        chk("R4", "off_o swapped", off_o, 64'h0100);
        chk("R4", "dst_o swapped", {60'd0, dst_o}, 64'h2);
    endtask

    task automatic t_load_store_view;
        // R2: mode/size view of a register load, double size
        send(mk(8'h79, 4'h0, 4'h1, 16'h0008, 32'h0, 1'b0), 1'b0, 1'b0);
        expect_status("R2", 1'b1, 1'b0, 1'b0);
        chk("R2", "mode_o", {61'd0, mode_o}, 64'h3);
        chk("R2", "size_o", {62'd0, size_o}, 64'h3);
        chk("R10", "class_hot_o", {56'd0, class_hot_o}, 64'h02);
    endtask

    task automatic t_wide(input logic be);
        // R6: two-slot load; second slot's non-immediate bytes are junk
        send(mk(8'h18, 4'h5, 4'h0, 16'h0000, 32'h89AB_CDEF, be), be, 1'b0);
        expect_status("R6", 1'b0, 1'b0, 1'b1);
        send(mk(8'hFF, 4'hF, 4'hF, 16'hFFFF, 32'h0123_4567, be), be, 1'b0);
        expect_status("R6", 1'b1, 1'b0, 1'b0);
        chk("R6", "wide_imm_o", wide_imm_o, 64'h0123_4567_89AB_CDEF);
        chk("R6", "wide_o", {63'd0, wide_o}, 64'd1);
        chk("R6", "dst_o kept", {60'd0, dst_o}, 64'h5);
        chk("R6", "opcode_o kept", {56'd0, opcode_o}, 64'h18);
    endtask

    task automatic t_reserved_modes;
        // R7: load class with modes 100, 101, and store class with mode 111
        send(mk(8'h80, 4'h0, 4'h0, 16'h0, 32'h0, 1'b0), 1'b0, 1'b1);
        expect_status("R7", 1'b0, 1'b1, 1'b0);
        send(mk(8'hB0, 4'h0, 4'h0, 16'h0, 32'h0, 1'b0), 1'b0, 1'b1);
        expect_status("R7", 1'b0, 1'b1, 1'b0);
        send(mk(8'hE2, 4'h0, 4'h0, 16'h0, 32'h0, 1'b0), 1'b0, 1'b1);
        expect_status("R7", 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_extended;
        // R8: signed divide ALU64 register, enable low then high
        send(mk(8'hEF, 4'h1, 4'h2, 16'h0, 32'h0, 1'b0), 1'b0, 1'b0);
        expect_status("R8", 1'b0, 1'b1, 1'b0);
        chk("R8", "ext_only_o", {63'd0, ext_only_o}, 64'd1);
        send(mk(8'hEF, 4'h1, 4'h2, 16'h0, 32'h0, 1'b0), 1'b0, 1'b1);
        expect_status("R8", 1'b1, 1'b0, 1'b0);
        chk("R8", "ext_only_o", {63'd0, ext_only_o}, 64'd1);
        // R8: signed modulo ALU immediate, enable low
        send(mk(8'hF4, 4'h1, 4'h0, 16'h0, 32'h7, 1'b0), 1'b0, 1'b0);
        expect_status("R8", 1'b0, 1'b1, 1'b0);
        // R8: call through register
        send(mk(8'h8D, 4'h4, 4'h0, 16'h0, 32'h0, 1'b0), 1'b0, 1'b0);
        expect_status("R8", 1'b0, 1'b1, 1'b0);
        send(mk(8'h8D, 4'h4, 4'h0, 16'h0, 32'h0, 1'b0), 1'b0, 1'b1);
        expect_status("R8", 1'b1, 1'b0, 1'b0);
        // R8: call with immediate is a base encoding
        send(mk(8'h85, 4'h0, 4'h0, 16'h0, 32'h10, 1'b0), 1'b0, 1'b0);
        expect_status("R8", 1'b1, 1'b0, 1'b0);
        chk("R8", "ext_only_o", {63'd0, ext_only_o}, 64'd0);
    endtask

    task automatic t_unknown;
        // R9: byte swap in ALU64 rejected, in ALU accepted
        send(mk(8'hD7, 4'h0, 4'h0, 16'h0, 32'h10, 1'b0), 1'b0, 1'b1);
        expect_status("R9", 1'b0, 1'b1, 1'b0);
        send(mk(8'hD4, 4'h0, 4'h0, 16'h0, 32'h10, 1'b0), 1'b0, 1'b1);
        expect_status("R9", 1'b1, 1'b0, 1'b0);
        // R9: JMP32 op 0x0 and op 0x9 rejected, op 0x1 accepted
        send(mk(8'h06, 4'h0, 4'h0, 16'h0, 32'h0, 1'b0), 1'b0, 1'b1);
        expect_status("R9", 1'b0, 1'b1, 1'b0);
        send(mk(8'h96, 4'h0, 4'h0, 16'h0, 32'h0, 1'b0), 1'b0, 1'b1);
        expect_status("R9", 1'b0, 1'b1, 1'b0);
        send(mk(8'h16, 4'h0, 4'h0, 16'h0, 32'h0, 1'b0), 1'b0, 1'b1);
        expect_status("R9", 1'b1, 1'b0, 1'b0);
        // R9: JMP op 0xE rejected
        send(mk(8'hE5, 4'h0, 4'h0, 16'h0, 32'h0, 1'b0), 1'b0, 1'b1);
        expect_status("R9", 1'b0, 1'b1, 1'b0);
        // R9: LD mode IMM at word size rejected
        send(mk(8'h00, 4'h0, 4'h0, 16'h0, 32'h0, 1'b0), 1'b0, 1'b1);
        expect_status("R9", 1'b0, 1'b1, 1'b0);
        // R9: ST mem word accepted, STX atomic byte rejected, STX atomic double accepted
        send(mk(8'h62, 4'h0, 4'h0, 16'h0, 32'h0, 1'b0), 1'b0, 1'b1);
        expect_status("R9", 1'b1, 1'b0, 1'b0);
        send(mk(8'hD3, 4'h0, 4'h0, 16'h0, 32'h0, 1'b0), 1'b0, 1'b1);
        expect_status("R9", 1'b0, 1'b1, 1'b0);
        send(mk(8'hDB, 4'h0, 4'h0, 16'h0, 32'h0, 1'b0), 1'b0, 1'b1);
        expect_status("R9", 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_idle;
        // R11: result pulses for one cycle, fields hold while idle
        send(mk(8'h07, 4'h6, 4'h0, 16'h00FF, 32'h55, 1'b0), 1'b0, 1'b0);
        expect_status("R11", 1'b1, 1'b0, 1'b0);
        slot_i = 64'hFFFF_FFFF_FFFF_FFFF;
        repeat (3) @(negedge clk);
        expect_status("R11", 1'b0, 1'b0, 1'b0);
        chk("R11", "dst_o hold", {60'd0, dst_o}, 64'h6);
        chk("R11", "imm_o hold", imm_o, 64'h55);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_little_alu();
        t_big_jump();
        t_load_store_view();
        t_wide(1'b0);
        t_wide(1'b1);
        t_reserved_modes();
        t_extended();
        t_unknown();
        t_idle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule